// File: doc/BRIEF.md
# Crosspoint Switch Programming Register Bank

This block is the digital control plane of a five-output crosspoint switch. Each output carries a 4-bit input select and an enable. Settings are staged first in a holding register. That register can be loaded in two ways. The parallel way writes one output at a time through an address and a data word, captured on a falling edge of a write strobe. The serial way shifts in a complete 45-bit image on rising edges of a serial clock.

A level-sensitive, active-low update control copies the holding register into a second-rank matrix register, and that register drives the switch. This double buffering lets several outputs be restaged while the switch keeps its current state; the new settings then take effect together. The active-low reset clears only the matrix register, which disables every output. The holding register keeps whatever it held, including unknown power-up contents, so software must load a full image before the first update.

All control inputs are sampled on `clk_i` and are assumed to be synchronous to it. Strobe edges are found by comparing each strobe with its value in the previous cycle.

Top module: `xbar_prog_ctrl`

## Requirements
- R1: While `rst_ni` is low, `en_o` and `sel_o` are all zero. After release they stay zero until the first update cycle.
- R2: A parallel write happens when `cs_ni`=0, `ser_par_i`=1 and `we_ni` goes from 1 to 0 between two consecutive clock samples. It stores `data_i` into the field of output `addr_i` at that clock edge.
- R3: While `update_ni` is high, `en_o` and `sel_o` do not change, whatever writes or shifts occur.
- R4: Each clock edge that samples `update_ni` low copies the holding register into the matrix register. The outputs show the result after that edge, so the outputs keep following the holding register while update stays low.
- R5: Output k uses holding bits [9k+8:9k]. Bit 9k+4 is its enable and bits [9k+3:9k] are its input select. A parallel data word has the same layout: bit 4 is the enable and bits 3:0 are the select. A parallel write leaves bits [9k+8:9k+5] unchanged. `en_o[k]` is the enable of output k and `sel_o[4k+3:4k]` is its select.
- R6: When output k is disabled, `sel_o[4k+3:4k]` reads zero, whatever select value is stored.
- R7: A parallel write to an address of 5, 6 or 7 changes nothing.
- R8: A falling edge of `we_ni` while `cs_ni`=1 or `ser_par_i`=0 changes nothing.
- R9: With `cs_ni`=0 and `ser_par_i`=0, each rising edge of `sclk_i` shifts `sdata_i` into holding bit 0 and moves every other bit up by one. After 45 rising edges, the first bit sent sits in bit 44, the most significant bit of output 4.
- R10: A rising edge of `sclk_i` while `cs_ni`=1 or `ser_par_i`=1 changes nothing.
- R11: Reset leaves the holding register intact, so an update after reset restores the image that was staged before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the matrix register |
| cs_ni | input | 1 | Active-low chip select |
| ser_par_i | input | 1 | Load mode: 1 selects parallel, 0 selects serial |
| we_ni | input | 1 | Parallel write strobe, acts on its falling edge |
| addr_i | input | 3 | Output index for a parallel write |
| data_i | input | 5 | Parallel data: bit 4 is the enable, bits 3:0 the input select |
| sclk_i | input | 1 | Serial shift clock, acts on its rising edge, rests high |
| sdata_i | input | 1 | Serial data bit |
| update_ni | input | 1 | Active-low, level-sensitive transfer to the matrix |
| en_o | output | 5 | Per-output enable |
| sel_o | output | 20 | Per-output input select, 4 bits per output, zero when disabled |

## Verification
The design takes two clock edges from a strobe to the holding register. The first edge samples the strobe at its old level, and the edge that sees the new level performs the write. The matrix output changes on the first clock edge that samples `update_ni` low, and there is no further register stage before `en_o` and `sel_o`. The bench drives every input on falling clock edges and reads the outputs on the falling edge right after the edge that should have acted. Its checks that outputs stay still with update high are made after the writes or shifts have fully completed.

// File: rtl/xbar_prog_pkg.sv
package xbar_prog_pkg;
  localparam int unsigned NUM_OUT = 5;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned FIELD_W = 9;
endpackage

// File: rtl/xbar_edge_det.sv
module xbar_edge_det #(
  parameter bit RISE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic gate_i,
  output logic pulse_o
);
  logic sig_q;

  // strobes rest high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b1;
    else         sig_q <= sig_i;
  end

  generate
    if (RISE) begin : g_rise
      assign pulse_o = gate_i & ~sig_q & sig_i;
    end else begin : g_fall
      assign pulse_o = gate_i & sig_q & ~sig_i;
    end
  endgenerate
endmodule

// File: rtl/xbar_hold_reg.sv
module xbar_hold_reg #(
  parameter int unsigned NumOut = xbar_prog_pkg::NUM_OUT,
  parameter int unsigned SelW   = xbar_prog_pkg::SEL_W,
  parameter int unsigned AddrW  = xbar_prog_pkg::ADDR_W,
  parameter int unsigned FieldW = xbar_prog_pkg::FIELD_W,
  localparam int unsigned DataW = SelW + 1,
  localparam int unsigned ImgW  = NumOut * FieldW
) (
  input  logic             clk_i,
  input  logic             wr_i,
  input  logic [AddrW-1:0] addr_i,
  input  logic [DataW-1:0] data_i,
  input  logic             shift_i,
  input  logic             sdata_i,
  output logic [ImgW-1:0]  hold_o
);
  logic [ImgW-1:0]   hold_q;
  logic [ImgW-1:0]   hold_d;
  logic [NumOut-1:0] wr_sel;

  for (genvar k = 0; k < NumOut; k++) begin : g_dec
    assign wr_sel[k] = wr_i && (addr_i == AddrW'(k));
  end

  always_comb begin
    hold_d = hold_q;
    if (shift_i) begin
      hold_d = {hold_q[ImgW-2:0], sdata_i};
    end else begin
      for (int k = 0; k < int'(NumOut); k++) begin
        if (wr_sel[k]) hold_d[k*FieldW +: DataW] = data_i;
      end
    end
  end

  // no reset: contents are undefined after power-up by intent
  always_ff @(posedge clk_i) begin
    hold_q <= hold_d;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/xbar_matrix_reg.sv
module xbar_matrix_reg #(
  parameter int unsigned NumOut = xbar_prog_pkg::NUM_OUT,
  parameter int unsigned SelW   = xbar_prog_pkg::SEL_W,
  parameter int unsigned FieldW = xbar_prog_pkg::FIELD_W,
  localparam int unsigned ImgW  = NumOut * FieldW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [ImgW-1:0]        img_i,
  output logic [NumOut-1:0]      en_o,
  output logic [NumOut*SelW-1:0] sel_o
);
  for (genvar k = 0; k < NumOut; k++) begin : g_out
    logic            en_q;
    logic [SelW-1:0] sel_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q  <= 1'b0;
        sel_q <= '0;
      end else if (load_i) begin
        en_q  <= img_i[k*FieldW + SelW];
        sel_q <= img_i[k*FieldW +: SelW];
      end
    end

    assign en_o[k]               = en_q;
    assign sel_o[k*SelW +: SelW] = en_q ? sel_q : '0;
  end
endmodule

// File: rtl/xbar_prog_ctrl.sv
module xbar_prog_ctrl #(
  parameter int unsigned NumOut = xbar_prog_pkg::NUM_OUT,
  parameter int unsigned SelW   = xbar_prog_pkg::SEL_W,
  parameter int unsigned AddrW  = xbar_prog_pkg::ADDR_W,
  parameter int unsigned FieldW = xbar_prog_pkg::FIELD_W,
  localparam int unsigned DataW = SelW + 1,
  localparam int unsigned ImgW  = NumOut * FieldW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   ser_par_i,
  input  logic                   we_ni,
  input  logic [AddrW-1:0]       addr_i,
  input  logic [DataW-1:0]       data_i,
  input  logic                   sclk_i,
  input  logic                   sdata_i,
  input  logic                   update_ni,
  output logic [NumOut-1:0]      en_o,
  output logic [NumOut*SelW-1:0] sel_o
);
  logic par_mode;
  logic ser_mode;
  logic wr_pulse;
  logic sh_pulse;
  logic [ImgW-1:0] hold_q;

  assign par_mode = ~cs_ni & ser_par_i;
  assign ser_mode = ~cs_ni & ~ser_par_i;

  xbar_edge_det #(.RISE(1'b0)) u_we_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sig_i   (we_ni),
    .gate_i  (par_mode),
    .pulse_o (wr_pulse)
  );

  xbar_edge_det #(.RISE(1'b1)) u_sclk_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sig_i   (sclk_i),
    .gate_i  (ser_mode),
    .pulse_o (sh_pulse)
  );

  xbar_hold_reg #(
    .NumOut (NumOut),
    .SelW   (SelW),
    .AddrW  (AddrW),
    .FieldW (FieldW)
  ) u_hold (
    .clk_i   (clk_i),
    .wr_i    (wr_pulse),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .shift_i (sh_pulse),
    .sdata_i (sdata_i),
    .hold_o  (hold_q)
  );

  xbar_matrix_reg #(
    .NumOut (NumOut),
    .SelW   (SelW),
    .FieldW (FieldW)
  ) u_matrix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (~update_ni),
    .img_i  (hold_q),
    .en_o   (en_o),
    .sel_o  (sel_o)
  );
endmodule

// File: rtl/xbar_prog_chk.sv
module xbar_prog_chk #(
  parameter int unsigned NumOut = xbar_prog_pkg::NUM_OUT,
  parameter int unsigned SelW   = xbar_prog_pkg::SEL_W,
  parameter int unsigned AddrW  = xbar_prog_pkg::ADDR_W,
  parameter int unsigned FieldW = xbar_prog_pkg::FIELD_W,
  localparam int unsigned ImgW  = NumOut * FieldW
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_ni,
  input logic                   ser_par_i,
  input logic                   we_ni,
  input logic [AddrW-1:0]       addr_i,
  input logic                   update_ni,
  input logic [NumOut-1:0]      en_o,
  input logic [NumOut*SelW-1:0] sel_o,
  input logic [ImgW-1:0]        hold_q
);
  function automatic logic [NumOut-1:0] f_en(input logic [ImgW-1:0] img);
    for (int k = 0; k < int'(NumOut); k++) f_en[k] = img[k*FieldW + SelW];
  endfunction

  // R1: matrix disabled during reset
  a_r1_reset_disabled: assert property (@(posedge clk_i)
    !rst_ni |-> (en_o == '0 && sel_o == '0));

  // R1: still disabled on the first sample after release
  a_r1_release_disabled: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (en_o == '0));

  a_r3_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_ni |=> ({en_o, sel_o} === $past({en_o, sel_o})));

  a_r4_follow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_ni |=> (en_o === f_en($past(hold_q))));

  a_r7_bad_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && ser_par_i && $past(we_ni) && !we_ni && addr_i >= AddrW'(NumOut))
    |=> (hold_q === $past(hold_q)));

  // R8, R10: deselected chip never alters the holding register
  a_r10_cs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (hold_q === $past(hold_q)));
endmodule

bind xbar_prog_ctrl xbar_prog_chk #(
  .NumOut (NumOut),
  .SelW   (SelW),
  .AddrW  (AddrW),
  .FieldW (FieldW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .ser_par_i (ser_par_i),
  .we_ni     (we_ni),
  .addr_i    (addr_i),
  .update_ni (update_ni),
  .en_o      (en_o),
  .sel_o     (sel_o),
  .hold_q    (hold_q)
);

// File: tb/test_xbar_prog_ctrl.sv
module test_xbar_prog_ctrl;
  localparam int N = 5;
  localparam int SW = 4;
  localparam int FW = 9;
  localparam int IW = N * FW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic ser_par_i = 1'b1;
  logic we_ni = 1'b1;
  logic [2:0] addr_i = '0;
  logic [4:0] data_i = '0;
  logic sclk_i = 1'b1;
  logic sdata_i = 1'b0;
  logic update_ni = 1'b1;
  logic [N-1:0] en_o;
  logic [N*SW-1:0] sel_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [IW-1:0] m_hold;
  logic [IW-1:0] m_mat;

  always #4 clk_i = ~clk_i;

  xbar_prog_ctrl i_xbar_prog_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .ser_par_i(ser_par_i),
    .we_ni(we_ni), .addr_i(addr_i), .data_i(data_i), .sclk_i(sclk_i),
    .sdata_i(sdata_i), .update_ni(update_ni), .en_o(en_o), .sel_o(sel_o)
  );

  function automatic logic [N-1:0] x_en(input logic [IW-1:0] img);
    for (int k = 0; k < N; k++) x_en[k] = img[k*FW + 4];
  endfunction

  function automatic logic [N*SW-1:0] x_sel(input logic [IW-1:0] img);
    for (int k = 0; k < N; k++)
      x_sel[k*SW +: SW] = img[k*FW + 4] ? img[k*FW +: SW] : 4'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    chk({req, " en"}, 32'(en_o), 32'(x_en(m_mat)));
    chk({req, " sel"}, 32'(sel_o), 32'(x_sel(m_mat)));
  endtask

  task automatic par_wr(input logic [2:0] a, input logic [4:0] d, input logic cs, input logic sp);
    @(negedge clk_i);
    cs_ni = cs; ser_par_i = sp; addr_i = a; data_i = d; we_ni = 1'b1;
    @(negedge clk_i);
    we_ni = 1'b0;
    @(negedge clk_i);
    we_ni = 1'b1;
    if (!cs && sp && a < 3'(N)) m_hold[a*FW +: 5] = d;
  endtask

  task automatic ser_load(input logic [IW-1:0] img, input logic cs, input logic sp);
    @(negedge clk_i);
    cs_ni = cs; ser_par_i = sp;
    for (int i = IW - 1; i >= 0; i--) begin
      @(negedge clk_i);
      sdata_i = img[i]; sclk_i = 1'b0;
      @(negedge clk_i);
      sclk_i = 1'b1;
      if (!cs && !sp) m_hold = {m_hold[IW-2:0], img[i]};
    end
    @(negedge clk_i);
    cs_ni = 1'b1; ser_par_i = 1'b1;
  endtask

  task automatic do_update;
    @(negedge clk_i);
    update_ni = 1'b0;
    @(negedge clk_i);
    update_ni = 1'b1;
    m_mat = m_hold;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] img;
    void'($urandom(32'h1f3a_77c5));
    m_mat = '0;
    m_hold = '0;
    repeat (3) @(negedge clk_i);
    chk_out("R1 in reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk_out("R1 after release");

    // first load: all outputs staged, update held high
    for (int k = 0; k < N; k++) par_wr(3'(k), 5'(16 + ((k * 3 + 1) % 16)), 1'b0, 1'b1);
    @(negedge clk_i);
    chk_out("R3 staged not visible");
    chk_out("R1 no update yet");
    do_update();
    chk_out("R2 R5 first update");

    // R6: disabled output with nonzero select reads zero
    par_wr(3'd2, 5'b0_1011, 1'b0, 1'b1);
    do_update();
    chk("R6 disabled sel", 32'(sel_o[8 +: 4]), 32'h0);
    chk_out("R6 image");

    // random parallel traffic
    for (int r = 0; r < 30; r++) begin
      for (int j = 0; j < 4; j++) par_wr(3'($urandom_range(0, 7)), 5'($urandom), 1'b0, 1'b1);
      @(negedge clk_i);
      chk_out("R3 R7 before update");
      do_update();
      chk_out("R2 R5 R7 random update");
    end

    // R7 directed: address 5..7
    par_wr(3'd5, 5'h1f, 1'b0, 1'b1);
    par_wr(3'd7, 5'h1a, 1'b0, 1'b1);
    do_update();
    chk_out("R7 bad address");

    // R8: strobe ignored when deselected or in serial mode
    par_wr(3'd0, ~m_hold[4:0], 1'b1, 1'b1);
    par_wr(3'd1, ~m_hold[FW +: 5], 1'b0, 1'b0);
    do_update();
    chk_out("R8 gated strobe");

    // serial loads
    for (int r = 0; r < 6; r++) begin
      img = {$urandom, $urandom};
      ser_load(img, 1'b0, 1'b0);
      chk_out("R3 serial before update");
      do_update();
      chk_out("R9 serial image");
    end

    // R9 directed: only output 4 enabled, select 9, first bit at bit 44
    img = '0;
    img[4*FW + 4] = 1'b1;
    img[4*FW +: 4] = 4'h9;
    ser_load(img, 1'b0, 1'b0);
    do_update();
    chk("R9 order en", 32'(en_o), 32'h10);
    chk("R9 order sel", 32'(sel_o), 32'h9_0000);

    // R10: shifting ignored when deselected or in parallel mode
    ser_load({$urandom, $urandom}, 1'b1, 1'b0);
    ser_load({$urandom, $urandom}, 1'b0, 1'b1);
    do_update();
    chk_out("R10 gated shift");

    // R4: update held low, outputs follow a write one edge after capture
    @(negedge clk_i);
    update_ni = 1'b0;
    par_wr(3'd3, 5'h17, 1'b0, 1'b1);
    m_mat = m_hold;
    @(negedge clk_i);
    chk_out("R4 follow while low");
    update_ni = 1'b1;

    // R11: reset keeps holding contents
    par_wr(3'd0, 5'h1c, 1'b0, 1'b1);
    do_update();
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_mat = '0;
    @(negedge clk_i);
    chk_out("R1 R11 reset clears matrix");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_out("R1 R11 stays disabled");
    do_update();
    chk_out("R11 holding survives reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule